// File: doc/BRIEF.md
# Chip-Select and Sleep Delay Timer

This block runs the two timing instructions of a command-driven serial-peripheral controller. A chip-select instruction waits for a programmed delay, loads a new value into the chip-select output register, and then waits for the same delay again. A sleep instruction stalls the command stream for a programmed number of delay units. The upstream sequencer offers one instruction at a time on a valid/ready handshake. The block raises ready whenever it is idle.

Every delay is measured in prescaled periods. One period lasts `2 * (prescale_div + 1)` fast clock cycles. A single unit counter times both halves of a chip-select instruction. A repeat flag records which half is running. When the first half ends, the flag sets, the new chip-select value is loaded, and the counters clear in that same cycle. The second half then starts at once. A chip-select instruction with a zero delay loads its value and finishes in a single cycle. `prescale_div` must stay stable while an instruction is in progress.

Top module: `spi_cs_sleep_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes idle with `instr_ready` high, and `cs_n` goes to all ones.
- R2: An instruction is accepted at an edge where `instr_valid` and `instr_ready` are both high. `instr_ready` is low in the cycle after acceptance and stays low until the instruction completes.
- R3: One delay unit is P = 2 * (`prescale_div` + 1) fast clock cycles.
- R4: A sleep instruction (`instr_kind` = 0) holds `instr_ready` low for exactly 2 + t*P cycles after the accepting edge, where t = `instr_arg[7:0]`.
- R5: For a chip-select instruction (`instr_kind` = 1) with d = `instr_arg[9:8]` nonzero, `cs_n` takes the value `instr_arg[CS_W-1:0]` at edge 1 + d*P after the accepting edge.
- R6: A chip-select instruction with nonzero d holds `instr_ready` low for exactly 2 + 2*d*P cycles.
- R7: A chip-select instruction with d = 0 loads `cs_n` at the first edge after acceptance and raises `instr_ready` at that same edge, so it is busy for one cycle.
- R8: While the block is busy, `instr_valid` and the instruction fields are ignored. They change neither the timing nor the `cs_n` value of the running instruction.
- R9: `cs_n` changes only while a chip-select instruction runs. It keeps its value through idle periods and through sleep instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prescale_div | input | DIV_W | Prescaler setting; one delay unit is 2*(value+1) cycles |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | High when idle and able to accept |
| instr_kind | input | 1 | 0 = sleep, 1 = chip-select |
| instr_arg | input | CSD_W+SLEEP_W | [9:8] chip-select delay, [7:0] sleep count, [CS_W-1:0] chip-select value |
| cs_n | output | CS_W | Registered chip-select lines, active low |

## Verification
The chip-select load, the setting of the repeat flag, and the clearing of both counters all happen at one edge. If those events are misaligned, the second delay half comes out one cycle long or short, or the chip-select changes at the wrong edge. The bench provokes this with every nonzero delay and with several prescaler settings. It records the cycle at which `cs_n` changes and the cycle at which `instr_ready` returns, and compares both against the closed-form counts 1 + d*P and 2 + 2*d*P. Some runs hold `instr_valid` high with unrelated fields throughout the busy time, to show that busy-time input cannot disturb that edge.

// File: rtl/spi_cst_pkg.sv
// Shared types for the chip-select / sleep delay timer.
// Assumes: a single-bit instruction kind selects between the two instructions.
package spi_cst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_RUN  = 2'd2
    } cst_state_t;

    typedef enum logic {
        OP_SLEEP = 1'b0,
        OP_CS    = 1'b1
    } cst_kind_t;
endpackage

// File: rtl/spi_cst_prescaler.sv
// Prescaler: counts fast cycles and emits one tick per delay unit of
// 2*(div+1) cycles. Assumes div_i is stable while enable_i is high.
// clear_i has priority over counting.
module spi_cst_prescaler #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             enable_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam int PC_W = DIV_W + 1;

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] last_c;

    // Final count of a unit: 2*div + 1.
    assign last_c = {div_i, 1'b1};
    assign tick_o = enable_i && (pc_q == last_c);

    // Fast-cycle counter, wrapping at the end of each unit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            pc_q <= '0;
        end else if (enable_i) begin
            pc_q <= tick_o ? '0 : pc_q + 1'b1;
        end
    end

    // R3
    pc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable_i |-> (pc_q <= last_c));
endmodule

// File: rtl/spi_cst_unit_counter.sv
// Unit counter: counts prescaler ticks and flags a match with the target.
// Assumes the controller clears it before a new target is applied.
module spi_cst_unit_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] target_i,
    output logic             match_o
);
    logic [CNT_W-1:0] uc_q;

    assign match_o = (uc_q == target_i);

    // Count one per completed delay unit; clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            uc_q <= '0;
        end else if (tick_i) begin
            uc_q <= uc_q + 1'b1;
        end
    end

    // R4
    uc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |-> (uc_q <= target_i));
endmodule

// File: rtl/spi_cs_sleep_timer.sv
// Chip-select / sleep delay timer (top).
// Runs one instruction at a time: sleep (wait t units after a one-cycle
// setup) or chip-select (wait d units, load chip-select, wait d units again).
// Assumes prescale_div is stable while busy and CS_W <= SLEEP_W.
module spi_cs_sleep_timer
    import spi_cst_pkg::*;
#(
    parameter int CS_W    = 4,
    parameter int DIV_W   = 4,
    parameter int SLEEP_W = 8,
    parameter int CSD_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DIV_W-1:0]         prescale_div,
    input  logic                     instr_valid,
    output logic                     instr_ready,
    input  logic                     instr_kind,
    input  logic [CSD_W+SLEEP_W-1:0] instr_arg,
    output logic [CS_W-1:0]          cs_n
);
    localparam int ARG_W   = CSD_W + SLEEP_W;
    localparam int CSD_LSB = SLEEP_W;

    cst_state_t          state_q;
    cst_kind_t           kind_q;
    logic [SLEEP_W-1:0]  target_q;
    logic                early_q;
    logic [CS_W-1:0]     payload_q;
    logic                repeat_q;
    logic [CS_W-1:0]     cs_q;

    logic accept, in_run, cs_kind, match, tick;
    logic pass_switch, cs_update, finish, counter_clear;
    logic [CSD_W-1:0] csd_field;

    assign csd_field     = instr_arg[ARG_W-1:CSD_LSB];
    assign instr_ready   = (state_q == ST_IDLE);
    assign accept        = instr_valid && instr_ready;
    assign in_run        = (state_q == ST_RUN);
    assign cs_kind       = (kind_q == OP_CS);
    assign pass_switch   = in_run && cs_kind && !early_q && match && !repeat_q;
    assign cs_update     = in_run && cs_kind && !repeat_q && (early_q || match);
    assign finish        = in_run && (cs_kind ? (early_q || (match && repeat_q)) : match);
    assign counter_clear = !in_run || pass_switch;
    assign cs_n          = cs_q;

    spi_cst_prescaler #(.DIV_W(DIV_W)) presc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (counter_clear),
        .enable_i (in_run),
        .div_i    (prescale_div),
        .tick_o   (tick)
    );

    spi_cst_unit_counter #(.CNT_W(SLEEP_W)) units_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (counter_clear),
        .tick_i   (tick),
        .target_i (target_q),
        .match_o  (match)
    );

    // Sequencing: idle -> (setup for sleep) -> run -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) state_q <= (instr_kind == OP_CS) ? ST_RUN : ST_PRE;
                ST_PRE:  state_q <= ST_RUN;
                ST_RUN:  if (finish) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the instruction fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= OP_SLEEP;
            target_q  <= '0;
            early_q   <= 1'b0;
            payload_q <= '0;
        end else if (accept) begin
            kind_q    <= cst_kind_t'(instr_kind);
            early_q   <= (csd_field == '0);
            payload_q <= instr_arg[CS_W-1:0];
            target_q  <= (instr_kind == OP_CS)
                         ? SLEEP_W'(csd_field)
                         : instr_arg[SLEEP_W-1:0];
        end
    end

    // Repeat flag: marks the second delay pass of a chip-select.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_run) begin
            repeat_q <= 1'b0;
        end else if (pass_switch) begin
            repeat_q <= 1'b1;
        end
    end

    // Chip-select output register, loaded between the two passes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= '1;
        end else if (cs_update) begin
            cs_q <= payload_q;
        end
    end

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready) |=> !instr_ready);

    // R9
    cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_n) |-> ($past(!instr_ready) && $past(kind_q == OP_CS)));

    // R6
    repeat_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        repeat_q |-> (kind_q == OP_CS && !early_q));

    // R5
    second_pass_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(repeat_q) |-> (!match || target_q == '0) && !instr_ready);
endmodule

// File: tb/spi_cs_sleep_timer_tb_top.sv
module spi_cs_sleep_timer_tb_top;
    localparam int CS_W = 4;
    localparam int DIV_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DIV_W-1:0] prescale_div = '0;
    logic instr_valid = 1'b0;
    logic instr_ready;
    logic instr_kind = 1'b0;
    logic [9:0] instr_arg = '0;
    logic [CS_W-1:0] cs_n;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    spi_cs_sleep_timer #(.CS_W(CS_W), .DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .prescale_div(prescale_div),
        .instr_valid(instr_valid), .instr_ready(instr_ready),
        .instr_kind(instr_kind), .instr_arg(instr_arg), .cs_n(cs_n)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one instruction at the sampling point; measure busy length and
    // the cycle of the chip-select change (-1 if none).
    task automatic run_instr(input logic kind, input logic [9:0] arg, input logic noisy,
                             output int busy_len, output int cs_edge);
        logic [CS_W-1:0] prev;
        int n;
        prev = cs_n;
        check("R2 ready before issue", int'(instr_ready), 1);
        instr_valid = 1'b1;
        instr_kind = kind;
        instr_arg = arg;
        @(posedge clk); #1;
        n = 0;
        cs_edge = -1;
        check("R2 ready low after accept", int'(instr_ready), 0);
        if (noisy) begin
            instr_kind = ~kind;
            instr_arg = ~arg;
        end else begin
            instr_valid = 1'b0;
        end
        while (!instr_ready && n < 5000) begin
            @(posedge clk); #1;
            n = n + 1;
            if (cs_n != prev && cs_edge < 0) cs_edge = n;
        end
        instr_valid = 1'b0;
        busy_len = n;
    endtask

    initial begin
        int len, edge_at, p, exp_edge;
        logic [CS_W-1:0] cur;
        int tvals[6] = '{0, 1, 2, 3, 7, 255};
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 ready after reset", int'(instr_ready), 1);
        check("R1 cs_n after reset", int'(cs_n), 15);
        rst_n = 1'b1;
        @(posedge clk); #1;
        cur = cs_n;
        for (int div = 0; div < 3; div++) begin
            prescale_div = DIV_W'(div);
            p = 2 * (div + 1);  // R3 delay unit
            // R4 sleep timing, R9 cs untouched by sleep
            for (int i = 0; i < 6; i++) begin
                run_instr(1'b0, 10'(tvals[i]), 1'b0, len, edge_at);
                check("R4 sleep length", len, 2 + tvals[i] * p);
                check("R9 sleep leaves cs_n", int'(cs_n), int'(cur));
            end
            // R5/R6/R7 chip-select timing, R8 busy-time input ignored
            for (int d = 0; d < 4; d++) begin
                for (int nz = 0; nz < 2; nz++) begin
                    logic [CS_W-1:0] pay;
                    pay = CS_W'(div * 5 + d * 3 + nz + 1);
                    run_instr(1'b1, {2'(d), 4'h0, pay}, nz[0], len, edge_at);
                    exp_edge = (pay == cur) ? -1 : ((d == 0) ? 1 : 1 + d * p);
                    if (d == 0) begin
                        check("R7 zero-delay length", len, 1);
                        check("R7 zero-delay cs edge", edge_at, exp_edge);
                    end else begin
                        check(nz ? "R8 length with busy noise" : "R6 cs length",
                              len, 2 + 2 * d * p);
                        check(nz ? "R8 cs edge with busy noise" : "R5 cs edge",
                              edge_at, exp_edge);
                    end
                    check(nz ? "R8 cs value with busy noise" : "R5 cs value",
                          int'(cs_n), int'(pay));
                    cur = pay;
                    // R9 value held through idle time
                    repeat (3) @(posedge clk);
                    #1;
                    check("R9 cs held idle", int'(cs_n), int'(cur));
                end
            end
        end
        // R1 reset mid-instruction
        run_instr(1'b0, 10'd0, 1'b0, len, edge_at);
        instr_valid = 1'b1; instr_kind = 1'b1; instr_arg = {2'd3, 8'h0A};
        @(posedge clk); #1;
        instr_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 ready after mid reset", int'(instr_ready), 1);
        check("R1 cs_n after mid reset", int'(cs_n), 15);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule